// File: doc/BRIEF.md
# SPI Master Chip-Select Delay Sequencer

This block paces the chip-select line of an SPI master around each data word. After a start request it can hold chip select active for a programmable time before the first serial clock edge. It then lets an external shifter move the bits. Once the shifter reports completion, it can hold chip select for a further programmable time before releasing it. An optional gap follows, and the next word cannot begin until the gap has ended. The serial shifter, the clock divider and any register access are separate blocks.

Each word carries three flags. The first keeps chip select active into the next word, which removes both the hold time of this word and the setup time of the next. The second enables the inter-word gap. The third says whether this word updates the gap settings or reuses the ones latched earlier. A mode input selects whether a chip-select pin is used at all; without one, the setup and hold times are skipped and `cs_n` stays high. When the clock-phase input is 0, the hold time is lengthened by a half-serial-clock cycle count supplied on `half_sclk`.

Top module: `spi_cs_sequencer`

## Requirements
- R1: With a chip-select pin in use, no kept select from the previous word and `setup_code` nonzero, `cs_n` is low and `shift_en` low for exactly `setup_code`+2 cycles before `shift_en` rises. A code of 0 inserts no setup cycles.
- R2: With `clk_phase`=1, a chip-select pin in use and `word_keep`=0, `cs_n` stays low for exactly `hold_code`+1 cycles after `shift_en` falls. A code of 0 inserts no hold cycles, so the release follows at once.
- R3: With `clk_phase`=0, a nonzero hold is lengthened by `half_sclk` cycles.
- R4: With `cs_mode`=0, `cs_n` stays 1 throughout, and neither setup nor hold cycles are inserted.
- R5: A word with `word_keep`=1 leaves `cs_n` low after it ends, inserts no hold, and the next word starts shifting with no setup cycles.
- R6: With the gap enabled, a non-kept word has one release cycle with `cs_n` high, followed by `gap_code`+2 gap cycles before `idle` returns. With the gap disabled, only the release cycle occurs. After a kept word, the gap runs with `cs_n` still low.
- R7: A start with `word_ctl_upd`=1 takes the gap enable and gap code from that word. With `word_ctl_upd`=0, the values latched for an earlier word are reused.
- R8: `shift_en` is high from the end of setup until the cycle after `shift_done`. `cs_n` is low throughout that time when a chip-select pin is in use.
- R9: `idle` is high only when a new start would be accepted. A start seen in any state other than idle or gap is ignored and launches no word.
- R10: A start seen during the gap is held pending. It launches its word one cycle after the gap ends, with `idle` staying low throughout.
- R11: Synchronous active-high `rst` drives `cs_n` high, `shift_en` low and `idle` high, and clears the kept-select state. The next word therefore receives its full setup time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_mode | input | 1 | 1 when a chip-select pin is in use |
| clk_phase | input | 1 | Serial clock phase setting; 0 extends the hold time |
| half_sclk | input | HALF_W | Module cycles in half a serial clock period |
| setup_code | input | SETUP_W | Setup delay code |
| hold_code | input | HOLD_W | Hold delay code |
| start | input | 1 | One-cycle word start request |
| word_keep | input | 1 | Keep chip select active after this word |
| word_gap_en | input | 1 | Inter-word gap enable for this word |
| word_gap_code | input | GAP_W | Inter-word gap code for this word |
| word_ctl_upd | input | 1 | 1: take gap enable and code from this word |
| shift_done | input | 1 | Shifter reports the word is complete |
| cs_n | output | 1 | Active-low chip select |
| shift_en | output | 1 | Enables the external shifter |
| idle | output | 1 | Ready to accept a start |

## Verification
The length checks on setup and hold assume that `setup_code`, `hold_code`, `clk_phase` and `half_sclk` stay constant while a setup or hold period is running. The end-of-shift check assumes that `shift_done` arrives only while `shift_en` is high. The stimulus changes configuration only at a word start or during a gap, and it raises `shift_done` for a single cycle after counting the shift cycles of the current word. Start requests last one cycle. The only starts issued outside idle are the two deliberate ones, one during shifting and one during the gap.

// File: rtl/spi_cs_seq_pkg.sv
package spi_cs_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_SHIFT   = 3'd2,
    ST_HOLD    = 3'd3,
    ST_RELEASE = 3'd4,
    ST_GAP     = 3'd5
  } seq_state_t;

  // Setup period in module cycles; zero code means no setup period.
  function automatic int unsigned setup_len(input int unsigned code);
    return (code == 0) ? 0 : code + 2;
  endfunction

  // Hold period; phase 0 adds the half serial clock count.
  function automatic int unsigned hold_len(input int unsigned code,
                                           input bit phase,
                                           input int unsigned half);
    if (code == 0) return 0;
    return code + 1 + (phase ? 0 : half);
  endfunction

  // Inter-word gap period.
  function automatic int unsigned gap_len(input int unsigned code);
    return code + 2;
  endfunction

endpackage

// File: rtl/spi_cs_delay_cnt.sv
module spi_cs_delay_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/spi_cs_word_reg.sv
module spi_cs_word_reg #(
  parameter int GAP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             pend_set,
  input  logic             in_keep,
  input  logic             in_gap_en,
  input  logic [GAP_W-1:0] in_gap_code,
  input  logic             in_upd,
  output logic             keep_q,
  output logic             gap_en_q,
  output logic [GAP_W-1:0] gap_code_q,
  output logic             pend_valid
);
  logic             p_keep, p_gap_en, p_upd;
  logic [GAP_W-1:0] p_gap_code;
  logic             s_keep, s_gap_en, s_upd;
  logic [GAP_W-1:0] s_gap_code;

  // A pending request takes precedence over the live inputs.
  always_comb begin
    s_keep     = pend_valid ? p_keep     : in_keep;
    s_gap_en   = pend_valid ? p_gap_en   : in_gap_en;
    s_gap_code = pend_valid ? p_gap_code : in_gap_code;
    s_upd      = pend_valid ? p_upd      : in_upd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      p_keep     <= 1'b0;
      p_gap_en   <= 1'b0;
      p_gap_code <= '0;
      p_upd      <= 1'b0;
    end else if (accept) begin
      pend_valid <= 1'b0;
    end else if (pend_set) begin
      pend_valid <= 1'b1;
      p_keep     <= in_keep;
      p_gap_en   <= in_gap_en;
      p_gap_code <= in_gap_code;
      p_upd      <= in_upd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      keep_q     <= 1'b0;
      gap_en_q   <= 1'b0;
      gap_code_q <= '0;
    end else if (accept) begin
      keep_q <= s_keep;
      if (s_upd) begin
        gap_en_q   <= s_gap_en;
        gap_code_q <= s_gap_code;
      end
    end
  end
endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
  import spi_cs_seq_pkg::*;
#(
  parameter int SETUP_W = 8,
  parameter int HOLD_W  = 8,
  parameter int GAP_W   = 6,
  parameter int HALF_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_mode,
  input  logic               clk_phase,
  input  logic [HALF_W-1:0]  half_sclk,
  input  logic [SETUP_W-1:0] setup_code,
  input  logic [HOLD_W-1:0]  hold_code,
  input  logic               start,
  input  logic               word_keep,
  input  logic               word_gap_en,
  input  logic [GAP_W-1:0]   word_gap_code,
  input  logic               word_ctl_upd,
  input  logic               shift_done,
  output logic               cs_n,
  output logic               shift_en,
  output logic               idle
);
  localparam int CNT_W = $clog2((1 << SETUP_W) + (1 << HOLD_W) + (1 << HALF_W) + (1 << GAP_W) + 4);

  seq_state_t       state, nxt;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             cnt_last;
  logic             keep_q, gap_en_q, pend_valid;
  logic [GAP_W-1:0] gap_code_q;

  // Named internal events, used by the bound checker.
  logic accept, pend_set, setup_active, hold_active, gap_active, shift_active;

  assign accept       = (state == ST_IDLE) && (start || pend_valid);
  assign pend_set     = (state == ST_GAP) && start && !pend_valid;
  assign setup_active = (state == ST_SETUP);
  assign hold_active  = (state == ST_HOLD);
  assign gap_active   = (state == ST_GAP);
  assign shift_active = (state == ST_SHIFT);

  logic [CNT_W-1:0] setup_ld, hold_ld, gap_ld;
  assign setup_ld = CNT_W'(setup_len(32'(setup_code)) - 1);
  assign hold_ld  = CNT_W'(hold_len(32'(hold_code), clk_phase, 32'(half_sclk)) - 1);
  assign gap_ld   = CNT_W'(gap_len(32'(gap_code_q)) - 1);

  spi_cs_word_reg #(.GAP_W(GAP_W)) u_word (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .pend_set    (pend_set),
    .in_keep     (word_keep),
    .in_gap_en   (word_gap_en),
    .in_gap_code (word_gap_code),
    .in_upd      (word_ctl_upd),
    .keep_q      (keep_q),
    .gap_en_q    (gap_en_q),
    .gap_code_q  (gap_code_q),
    .pend_valid  (pend_valid)
  );

  spi_cs_delay_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .last     (cnt_last)
  );

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          // keep_q still holds the previous word's flag here
          if (cs_mode && !keep_q && (setup_code != '0)) begin
            nxt      = ST_SETUP;
            load     = 1'b1;
            load_val = setup_ld;
          end else begin
            nxt = ST_SHIFT;
          end
        end
      end
      ST_SETUP: if (cnt_last) nxt = ST_SHIFT;
      ST_SHIFT: begin
        if (shift_done) begin
          if (keep_q) begin
            if (gap_en_q) begin
              nxt      = ST_GAP;
              load     = 1'b1;
              load_val = gap_ld;
            end else begin
              nxt = ST_IDLE;
            end
          end else if (cs_mode && (hold_code != '0)) begin
            nxt      = ST_HOLD;
            load     = 1'b1;
            load_val = hold_ld;
          end else begin
            nxt = ST_RELEASE;
          end
        end
      end
      ST_HOLD: if (cnt_last) nxt = ST_RELEASE;
      ST_RELEASE: begin
        if (gap_en_q) begin
          nxt      = ST_GAP;
          load     = 1'b1;
          load_val = gap_ld;
        end else begin
          nxt = ST_IDLE;
        end
      end
      ST_GAP: if (cnt_last) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  logic cs_active;
  always_comb begin
    cs_active = setup_active || shift_active || hold_active ||
                (((state == ST_IDLE) || gap_active) && keep_q);
  end

  assign cs_n     = !(cs_mode && cs_active);
  assign shift_en = shift_active;
  assign idle     = (state == ST_IDLE) && !pend_valid;
endmodule

// File: rtl/spi_cs_seq_chk.sv
module spi_cs_seq_chk
  import spi_cs_seq_pkg::*;
#(
  parameter int SETUP_W = 8,
  parameter int HOLD_W  = 8,
  parameter int HALF_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               cs_mode,
  input logic               clk_phase,
  input logic [HALF_W-1:0]  half_sclk,
  input logic [SETUP_W-1:0] setup_code,
  input logic [HOLD_W-1:0]  hold_code,
  input logic               shift_done,
  input logic               shift_en,
  input logic               cs_n,
  input logic               idle,
  input logic               setup_active,
  input logic               hold_active
);
  logic        armed;
  logic [15:0] su_cnt, ho_cnt;

  always_ff @(posedge clk) begin
    armed  <= !rst;
    su_cnt <= (rst || !setup_active) ? 16'd0 : su_cnt + 16'd1;
    ho_cnt <= (rst || !hold_active)  ? 16'd0 : ho_cnt + 16'd1;
  end

  p_setup_len_r1: assert property (@(posedge clk) disable iff (rst)
    (armed && $fell(setup_active)) |-> (32'(su_cnt) == setup_len(32'(setup_code))));

  p_setup_cs_r1: assert property (@(posedge clk) disable iff (rst)
    setup_active |-> (!cs_n && !shift_en));

  p_hold_len_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && $fell(hold_active)) |->
      (32'(ho_cnt) == hold_len(32'(hold_code), clk_phase, 32'(half_sclk))));

  p_shift_cs_r8: assert property (@(posedge clk) disable iff (rst)
    (shift_en && cs_mode) |-> !cs_n);

  p_done_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (shift_en && shift_done) |=> !shift_en);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    idle |-> !shift_en);
endmodule

bind spi_cs_sequencer spi_cs_seq_chk #(
  .SETUP_W(SETUP_W), .HOLD_W(HOLD_W), .HALF_W(HALF_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cs_mode      (cs_mode),
  .clk_phase    (clk_phase),
  .half_sclk    (half_sclk),
  .setup_code   (setup_code),
  .hold_code    (hold_code),
  .shift_done   (shift_done),
  .shift_en     (shift_en),
  .cs_n         (cs_n),
  .idle         (idle),
  .setup_active (setup_active),
  .hold_active  (hold_active)
);

// File: tb/spi_cs_sequencer_test.sv
module spi_cs_sequencer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_mode = 1'b1, clk_phase = 1'b1;
  logic [7:0] half_sclk = '0, setup_code = '0, hold_code = '0;
  logic       start = 1'b0, word_keep = 1'b0, word_gap_en = 1'b0, word_ctl_upd = 1'b0;
  logic [5:0] word_gap_code = '0;
  logic       shift_done = 1'b0;
  logic       cs_n, shift_en, idle;

  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  spi_cs_sequencer uut (
    .clk(clk), .rst(rst), .cs_mode(cs_mode), .clk_phase(clk_phase),
    .half_sclk(half_sclk), .setup_code(setup_code), .hold_code(hold_code),
    .start(start), .word_keep(word_keep), .word_gap_en(word_gap_en),
    .word_gap_code(word_gap_code), .word_ctl_upd(word_ctl_upd),
    .shift_done(shift_done), .cs_n(cs_n), .shift_en(shift_en), .idle(idle)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0] su; logic [7:0] ho; logic [5:0] gp;
    logic ge; logic kp; logic up; logic md; logic ph;
    logic [7:0] hf; logic [7:0] sl;
  } vec_t;

  // setup, hold, gap, gap_en, keep, upd, mode, phase, half, shift length
  localparam vec_t VECS [11] = '{
    '{1,   1,   0,  1, 0, 1, 1, 1, 0, 4},
    '{0,   0,   0,  0, 0, 1, 1, 1, 0, 3},
    '{5,   3,   4,  1, 0, 1, 1, 0, 3, 2},
    '{2,   2,   0,  0, 1, 1, 1, 1, 0, 5},
    '{9,   4,   0,  0, 1, 1, 1, 1, 0, 2},
    '{3,   2,   1,  1, 0, 1, 1, 0, 2, 3},
    '{255, 255, 63, 1, 0, 1, 1, 0, 5, 1},
    '{4,   4,   2,  1, 0, 1, 0, 0, 3, 2},
    '{6,   0,   0,  0, 0, 0, 1, 1, 0, 2},
    '{1,   3,   3,  1, 1, 1, 1, 1, 0, 2},
    '{2,   0,   0,  0, 0, 1, 1, 1, 0, 1}
  };

  // Model state kept by the bench
  bit m_prev_keep = 0, m_gen = 0;
  int m_gcode = 0;

  task automatic drive(input vec_t v);
    setup_code = v.su; hold_code = v.ho; word_gap_code = v.gp;
    word_gap_en = v.ge; word_keep = v.kp; word_ctl_upd = v.up;
    cs_mode = v.md; clk_phase = v.ph; half_sclk = v.hf;
  endtask

  task automatic run_word(input vec_t v, output int pre, output int hold, output int post);
    int ph = 0, sc = 0;
    pre = 0; hold = 0; post = 0;
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int g = 0; g < 3000; g++) begin
      if (ph == 0) begin
        if (shift_en) begin
          ph = 1; sc = 1;
          if (sc >= int'(v.sl)) shift_done = 1'b1;
        end else pre++;
      end else if (ph == 1) begin
        shift_done = 1'b0;
        if (shift_en) begin
          sc++;
          if (sc >= int'(v.sl)) shift_done = 1'b1;
        end else ph = 2;
      end
      if (ph == 2) begin
        if (idle) break;
        if (!cs_n) hold++; else post++;
      end
      @(negedge clk);
    end
  endtask

  task automatic expect_word(input vec_t v, output int pe, output int he, output int qe);
    int gl;
    if (v.up) begin m_gen = v.ge; m_gcode = int'(v.gp); end
    gl = m_gen ? m_gcode + 2 : 0;
    pe = (v.md && !m_prev_keep && v.su != 0) ? int'(v.su) + 2 : 0;
    if (v.kp) begin
      he = v.md ? gl : 0;
      qe = v.md ? 0 : gl;
    end else begin
      he = (v.md && v.ho != 0) ? int'(v.ho) + 1 + (v.ph ? 0 : int'(v.hf)) : 0;
      qe = 1 + gl;
    end
    m_prev_keep = v.kp;
  endtask

  initial begin
    int pa, ha, qa, pe, he, qe;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 cs_n in reset", int'(cs_n), 1);
    check("R11 shift_en in reset", int'(shift_en), 0);
    check("R9 idle after reset", int'(idle), 1);
    rst = 1'b0;

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R8
    foreach (VECS[i]) begin
      run_word(VECS[i], pa, ha, qa);
      expect_word(VECS[i], pe, he, qe);
      check($sformatf("R1/R4/R5 setup cycles row %0d", i), pa, pe);
      check($sformatf("R2/R3/R5 hold cycles row %0d", i), ha, he);
      check($sformatf("R6/R7 release+gap cycles row %0d", i), qa, qe);
    end
    check("R5 cs_n low after kept word is not expected here", int'(cs_n), 1);

    // R10: start during gap is held pending
    begin
      vec_t a;
      int n, r, seen_idle;
      a = '{0, 0, 10, 1, 0, 1, 1, 1, 0, 2};
      @(negedge clk);
      drive(a); start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!shift_en) @(negedge clk);
      @(negedge clk); shift_done = 1'b1;
      @(negedge clk); shift_done = 1'b0;   // release cycle now
      r = int'(cs_n);
      check("R6 release cycle cs_n high", r, 1);
      @(negedge clk); @(negedge clk);      // second gap cycle
      word_gap_en = 1'b0; word_ctl_upd = 1'b1; setup_code = 8'd0;
      start = 1'b1;
      n = 0; seen_idle = 0;
      @(negedge clk); start = 1'b0; n = 1;
      while (!shift_en && n < 100) begin
        if (idle) seen_idle = 1;
        @(negedge clk); n++;
      end
      check("R10 cycles from gap start to pending shift", n, 12);
      check("R10 idle stays low while pending", seen_idle, 0);
      @(negedge clk); shift_done = 1'b1;
      @(negedge clk); shift_done = 1'b0;
      while (!idle) @(negedge clk);
    end

    // R9: start during shifting is ignored
    begin
      int bad;
      @(negedge clk);
      setup_code = 8'd2; hold_code = 8'd1; word_keep = 1'b0;
      word_gap_en = 1'b0; word_ctl_upd = 1'b1; start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!shift_en) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk); shift_done = 1'b1;
      @(negedge clk); shift_done = 1'b0;
      while (!idle) @(negedge clk);
      bad = 0;
      repeat (10) begin
        @(negedge clk);
        if (shift_en || !idle || !cs_n) bad++;
      end
      check("R9 ignored start launches no word", bad, 0);
    end

    // R11: reset clears kept select
    begin
      vec_t k, f;
      k = '{2, 0, 0, 0, 1, 1, 1, 1, 0, 2};
      f = '{2, 0, 0, 0, 0, 1, 1, 1, 0, 2};
      m_prev_keep = 0;
      run_word(k, pa, ha, qa);
      check("R5 cs_n held low after kept word", int'(cs_n), 0);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R11 cs_n released by reset", int'(cs_n), 1);
      check("R11 idle after reset", int'(idle), 1);
      run_word(f, pa, ha, qa);
      check("R11 full setup after reset", pa, 4);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule